// File: doc/BRIEF.md
# Descriptor List Walker

This block is the sequencer that a host controller uses to traverse a schedule of linked descriptors in memory. Queue heads are chained by horizontal links, and each queue head points to a chain of transfer descriptors. The walker reads descriptor words one at a time over a request/acknowledge memory port. It decides which descriptor to visit next, hands each active transfer to an external transaction stub, and writes the completed transfer's token back. When the walk is finished it returns to an idle-ready state.

A mode input selects the schedule type. In asynchronous mode a walk first searches the ring for the queue head flagged as list head. It then circles the ring and stops on a pass over the head that executed nothing. In periodic mode the walk starts directly from the given entry pointer and ends at an invalid or terminating link. A guard counter abandons any walk that visits too many queue heads without executing a transfer.

Top module: `sched_walker`

## Requirements
- R1: After reset `state_o` is 0 (idle) with `mem_req` and `xact_req` low. While idle, `sched_en` high moves the walker to 1 (ready). In ready, `sched_en` low returns it to 0. State codes: 0 idle, 1 ready, 2 transaction busy, 3 sleep, 4 head search, 5 entry decode, 6 queue-head fetch, 7 iso fetch, 8 queue advance, 9 transfer fetch, 10 execute, 11 write-back, 12 horizontal move.
- R2: A one-cycle `kick` in ready starts a walk. In asynchronous mode (`async_mode`=1) it enters head search when `list_base` is nonzero. With `list_base` zero the kick is ignored and the walker stays in ready with no memory access.
- R3: Head search reads the link word (offset 0) and the flags word (offset 4, bit 15 marks the head) of each queue head. On a head it sets the fetch pointer to that address with bit 1 set and goes to entry decode. It follows links otherwise. It returns to ready when a link's bits [31:5] equal those of `list_base`, or after examining MAX_ITER queue heads.
- R4: Entry decode returns to ready for any pointer below 0x1000. Otherwise it uses type bits [2:1]: 1 selects a queue head, 0 selects an iso descriptor, and any other value returns to ready.
- R5: A queue head is six words: link, flags, current transfer pointer, next pointer, alternate pointer, token. In the token, bit 6 is halted, bit 7 is active and bits [30:16] are the remaining byte count. A halted token leads to the horizontal move. An active token with a current pointer above 0x1000 leads to transfer fetch at that pointer. Any other queue head leads to queue advance.
- R6: In asynchronous mode, reaching the head queue head with the reclamation flag clear ends the walk in ready. Reaching it with the flag set clears the flag and continues. The flag is set when a walk starts and on every execute.
- R7: Queue advance takes the alternate pointer if the byte count is nonzero, the pointer exceeds 0x1000 and its bit 0 is 0. Failing that, it takes the next pointer under the same pointer test. Failing both, it goes to the horizontal move.
- R8: A transfer descriptor is three words: next, alternate, token. Its words replace the working next, alternate and token values. An active token leads to execute, and an inactive one leads to the horizontal move.
- R9: Execute raises `xact_req` with `xact_qtd` holding the descriptor address until `xact_ack`. If `xact_nak` is 1 the walker makes the horizontal move with no memory write. Otherwise it writes the token with bit 7 cleared to descriptor offset 8, then always goes to queue advance.
- R10: The horizontal move loads the queue head's link and goes to entry decode if the link differs from the current fetch pointer. Otherwise it returns to ready.
- R11: Each entry into queue-head fetch counts one visit, and execute clears the count. An entry that would make the count exceed MAX_ITER goes to ready instead.
- R12: An iso descriptor is read as one word, which becomes the next fetch pointer for entry decode. In periodic mode a kick loads `list_base` as the fetch pointer and goes straight to entry decode.
- R13: The memory port moves one 32-bit word per `mem_req`/`mem_ack` handshake. `mem_addr` stays stable while a request waits for its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_en | input | 1 | Schedule enable |
| async_mode | input | 1 | 1 asynchronous ring, 0 periodic list |
| kick | input | 1 | Start a walk from ready |
| list_base | input | 32 | Ring start address or periodic entry pointer |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| xact_req | output | 1 | Transaction request to stub |
| xact_qtd | output | 32 | Address of descriptor being executed |
| xact_ack | input | 1 | Transaction done |
| xact_nak | input | 1 | Transaction was refused |
| state_o | output | 4 | Current state code |

## Verification
Nearly every internal error shows at the ports within one descriptor visit. A wrong decision sends the next `mem_addr` to a different descriptor, issues an extra or missing `xact_req`, or produces a write with the wrong token. A faulty visit counter or reclamation flag does not alter any single step. It appears only at the end of a walk, as too many or too few queue-head fetches before the return to ready. For that reason the bench counts queue-head entries and head-search reads over whole walks, in addition to checking the order of executed descriptors and the write-back values.

// File: rtl/sched_walker.sv
module sched_walker #(
  parameter int MAX_ITER = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sched_en,
  input  logic        async_mode,
  input  logic        kick,
  input  logic [31:0] list_base,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        xact_req,
  output logic [31:0] xact_qtd,
  input  logic        xact_ack,
  input  logic        xact_nak,
  output logic [3:0]  state_o
);
  localparam int IW = $clog2(MAX_ITER + 1);
  localparam logic [31:0] LOW_LIMIT = 32'h1000;
  localparam int HEAD_BIT = 15;
  localparam int ACT_BIT  = 7;
  localparam int HALT_BIT = 6;

  typedef enum logic [3:0] {
    S_IDLE = 4'd0, S_READY = 4'd1, S_BUSY = 4'd2, S_SLEEP = 4'd3,
    S_HUNT = 4'd4, S_ENTRY = 4'd5, S_QHEAD = 4'd6, S_ISO = 4'd7,
    S_ADV = 4'd8, S_QTD = 4'd9, S_EXEC = 4'd10, S_WBACK = 4'd11,
    S_HORIZ = 4'd12
  } st_t;

  st_t st;
  logic [2:0]    widx, last_w;
  logic [31:0]   fetch_addr, scan_addr, qh_addr, qh_link, qh_cur;
  logic [31:0]   ovl_next, ovl_alt, ovl_tok, qtd_addr, base;
  logic          qh_head, recl;
  logic [IW-1:0] iter;

  always_comb begin
    case (st)
      S_HUNT:  base = scan_addr;
      S_QHEAD: base = qh_addr;
      S_ISO:   base = fetch_addr;
      default: base = qtd_addr;
    endcase
    case (st)
      S_HUNT:  last_w = 3'd1;
      S_QHEAD: last_w = 3'd5;
      S_QTD:   last_w = 3'd2;
      default: last_w = 3'd0;
    endcase
  end

  assign mem_req   = (st == S_HUNT) || (st == S_QHEAD) || (st == S_ISO) ||
                     (st == S_QTD) || (st == S_WBACK);
  assign mem_we    = (st == S_WBACK);
  assign mem_addr  = (base & ~32'h1F) + {27'd0, (st == S_WBACK) ? 3'd2 : widx, 2'b00};
  assign mem_wdata = ovl_tok & ~(32'd1 << ACT_BIT);
  assign xact_req  = (st == S_BUSY);
  assign xact_qtd  = qtd_addr;
  assign state_o   = st;

  wire fin       = mem_ack && (widx == last_w);
  wire alt_ok    = (ovl_alt > LOW_LIMIT) && !ovl_alt[0];
  wire next_ok   = (ovl_next > LOW_LIMIT) && !ovl_next[0];
  wire take_alt  = (ovl_tok[30:16] != 15'd0) && alt_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      widx <= '0;
      fetch_addr <= '0; scan_addr <= '0; qh_addr <= '0; qh_link <= '0;
      qh_cur <= '0; ovl_next <= '0; ovl_alt <= '0; ovl_tok <= '0;
      qtd_addr <= '0; qh_head <= 1'b0; recl <= 1'b0; iter <= '0;
    end else begin
      if (mem_req && mem_ack) widx <= fin ? 3'd0 : widx + 3'd1;
      case (st)
        S_IDLE: if (sched_en) st <= S_READY;
        S_READY: begin
          widx <= '0;
          if (!sched_en) st <= S_IDLE;
          else if (kick) begin
            iter <= '0;
            if (async_mode) begin
              if (list_base != 32'd0) begin
                scan_addr <= list_base;
                recl <= 1'b1;
                st <= S_HUNT;
              end
            end else begin
              fetch_addr <= list_base;
              st <= S_ENTRY;
            end
          end
        end
        S_HUNT: if (mem_ack) begin
          if (widx == 3'd0) qh_link <= mem_rdata;
          else if (mem_rdata[HEAD_BIT]) begin
            fetch_addr <= scan_addr | (async_mode ? 32'h2 : 32'h0);
            iter <= '0;
            st <= S_ENTRY;
          end else if ((qh_link[31:5] == list_base[31:5]) ||
                       (iter == IW'(MAX_ITER - 1))) begin
            st <= S_READY;
          end else begin
            scan_addr <= qh_link;
            iter <= iter + 1'b1;
          end
        end
        S_ENTRY: begin
          if (fetch_addr < LOW_LIMIT) st <= S_READY;
          else begin
            case (fetch_addr[2:1])
              2'd1: begin
                if (iter == IW'(MAX_ITER)) st <= S_READY;
                else begin
                  iter <= iter + 1'b1;
                  qh_addr <= fetch_addr;
                  st <= S_QHEAD;
                end
              end
              2'd0: st <= S_ISO;
              default: st <= S_READY;
            endcase
          end
        end
        S_QHEAD: if (mem_ack) begin
          case (widx)
            3'd0: qh_link <= mem_rdata;
            3'd1: qh_head <= mem_rdata[HEAD_BIT];
            3'd2: qh_cur <= mem_rdata;
            3'd3: ovl_next <= mem_rdata;
            3'd4: ovl_alt <= mem_rdata;
            default: begin
              ovl_tok <= mem_rdata;
              if (async_mode && qh_head && !recl) st <= S_READY;
              else begin
                if (async_mode && qh_head) recl <= 1'b0;
                if (mem_rdata[HALT_BIT]) st <= S_HORIZ;
                else if (mem_rdata[ACT_BIT] && (qh_cur > LOW_LIMIT)) begin
                  qtd_addr <= qh_cur;
                  st <= S_QTD;
                end else st <= S_ADV;
              end
            end
          endcase
        end
        S_ISO: if (mem_ack) begin
          fetch_addr <= mem_rdata;
          st <= S_ENTRY;
        end
        S_ADV: begin
          if (take_alt) begin
            qtd_addr <= ovl_alt;
            st <= S_QTD;
          end else if (next_ok) begin
            qtd_addr <= ovl_next;
            st <= S_QTD;
          end else st <= S_HORIZ;
        end
        S_QTD: if (mem_ack) begin
          case (widx)
            3'd0: ovl_next <= mem_rdata;
            3'd1: ovl_alt <= mem_rdata;
            default: begin
              ovl_tok <= mem_rdata;
              st <= mem_rdata[ACT_BIT] ? S_EXEC : S_HORIZ;
            end
          endcase
        end
        S_EXEC: begin
          iter <= '0;
          recl <= 1'b1;
          st <= S_BUSY;
        end
        S_BUSY: if (xact_ack) st <= xact_nak ? S_HORIZ : S_WBACK;
        S_WBACK: if (mem_ack) begin
          ovl_tok[ACT_BIT] <= 1'b0;
          st <= S_ADV;
        end
        S_HORIZ: begin
          if (fetch_addr != qh_link) begin
            fetch_addr <= qh_link;
            st <= S_ENTRY;
          end else st <= S_READY;
        end
        default: st <= S_READY;
      endcase
    end
  end

  // R4
  bad_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ENTRY && fetch_addr < LOW_LIMIT) |=> (st == S_READY));
  // R5
  qtd_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_QTD && $past(st) == S_QHEAD) |-> (qtd_addr > LOW_LIMIT));
  // R9
  exec_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EXEC) |=> (st == S_BUSY && xact_req));
  // R9
  wb_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WBACK && mem_ack) |=> (st == S_ADV));
  // R10
  horiz_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HORIZ) |=> (st == S_ENTRY || st == S_READY));
  // R11
  iter_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iter <= IW'(MAX_ITER));
  // R13
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> $stable(mem_addr));
endmodule

// File: tb/sched_walker_bench.sv
module sched_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXI = 16;

  logic clk = 1'b0, rst_n = 1'b0, sched_en = 1'b0, async_mode = 1'b0, kick = 1'b0;
  logic [31:0] list_base = '0;
  logic mem_req, mem_we, xact_req;
  logic [31:0] mem_addr, mem_wdata, xact_qtd;
  logic mem_ack = 1'b0, xact_ack = 1'b0, xact_nak = 1'b0, nak_mode = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [3:0] state_o;

  sched_walker #(.MAX_ITER(MAXI)) u_sched_walker (
    .clk(clk), .rst_n(rst_n), .sched_en(sched_en), .async_mode(async_mode),
    .kick(kick), .list_base(list_base), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .xact_req(xact_req), .xact_qtd(xact_qtd),
    .xact_ack(xact_ack), .xact_nak(xact_nak), .state_o(state_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem [0:1023];
  logic [31:0] xl [0:7];
  logic [31:0] wa [0:7];
  logic [31:0] wd [0:7];
  int n_x, n_wr, n_qh, n_fe, n_iso, n_hunt, bad_hold, reqs_seen;
  int tests = 0, fails = 0, cyc = 0;
  logic [3:0] prev_st = 4'd0;
  logic p_req = 1'b0, p_ack = 1'b0;
  logic [31:0] p_addr = '0;

  always @(negedge clk) begin
    cyc++;
    if (mem_req && p_req && !p_ack && mem_addr != p_addr) bad_hold++;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      reqs_seen++;
      if (mem_we) begin
        if (mem_addr[31:12] == 20'd1) mem[mem_addr[11:2]] = mem_wdata;
        if (n_wr < 8) begin wa[n_wr] = mem_addr; wd[n_wr] = mem_wdata; end
        n_wr++;
      end else begin
        mem_rdata = (mem_addr[31:12] == 20'd1) ? mem[mem_addr[11:2]] : 32'd0;
        if (state_o == 4'd4 && mem_addr[4:0] == 5'd0) n_hunt++;
      end
      mem_ack = 1'b1;
    end
    p_req = mem_req; p_addr = mem_addr; p_ack = mem_ack;
    if (xact_ack) xact_ack = 1'b0;
    else if (xact_req) begin
      xact_ack = 1'b1;
      xact_nak = nak_mode;
      if (n_x < 8) xl[n_x] = xact_qtd;
      n_x++;
    end
    if (state_o == 4'd6 && prev_st != 4'd6) n_qh++;
    if (state_o == 4'd5 && prev_st != 4'd5) n_fe++;
    if (state_o == 4'd7 && prev_st != 4'd7) n_iso++;
    prev_st = state_o;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
    n_x = 0; n_wr = 0; n_qh = 0; n_fe = 0; n_iso = 0; n_hunt = 0; reqs_seen = 0;
  endtask

  task automatic put_qh(input logic [31:0] a, input logic [31:0] link, input logic [31:0] flags,
                        input logic [31:0] cur, input logic [31:0] nxt, input logic [31:0] alt,
                        input logic [31:0] tok);
    mem[a[11:2]] = link; mem[a[11:2]+1] = flags; mem[a[11:2]+2] = cur;
    mem[a[11:2]+3] = nxt; mem[a[11:2]+4] = alt; mem[a[11:2]+5] = tok;
  endtask

  task automatic put_qtd(input logic [31:0] a, input logic [31:0] nxt, input logic [31:0] alt,
                         input logic [31:0] tok);
    mem[a[11:2]] = nxt; mem[a[11:2]+1] = alt; mem[a[11:2]+2] = tok;
  endtask

  task automatic walk(input bit am, input logic [31:0] b);
    async_mode = am; list_base = b; kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    for (int i = 0; i < 5000 && state_o != 4'd1; i++) @(negedge clk);
  endtask

  initial begin
    clr_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(state_o == 4'd0 && !mem_req && !xact_req, "R1", state_o, 0);
    rst_n = 1'b1; sched_en = 1'b1;
    @(negedge clk);
    chk(state_o == 4'd1, "R1", state_o, 1);

    // R2 zero base ignored in async mode
    walk(1'b1, 32'd0);
    repeat (3) @(negedge clk);
    chk(state_o == 4'd1 && reqs_seen == 0, "R2", reqs_seen, 0);

    // R3 R5 R6 R9 R10 async ring: head found, halted QH skipped, reclamation pass
    clr_mem();
    put_qh(32'h1000, 32'h1042, 32'h0, 32'h0, 32'h1, 32'h1, 32'h40);
    put_qh(32'h1040, 32'h1002, 32'h8000, 32'h1400, 32'h1, 32'h1, 32'h80);
    put_qtd(32'h1400, 32'h1, 32'h1, 32'h80);
    walk(1'b1, 32'h1000);
    chk(n_x == 1 && xl[0] == 32'h1400, "R9", xl[0], 32'h1400);
    chk(n_wr == 1 && wa[0] == 32'h1408 && wd[0] == 32'h0, "R9", wa[0], 32'h1408);
    chk(n_qh == 5, "R6", n_qh, 5);
    chk(n_hunt == 2, "R3", n_hunt, 2);
    chk(state_o == 4'd1, "R10", state_o, 1);

    // R7 R8 R12 periodic: alternate then next pointer, terminate ends chain
    clr_mem();
    put_qh(32'h1800, 32'h1, 32'h0, 32'h0, 32'h1600, 32'h1500, 32'h0003_0000);
    put_qtd(32'h1500, 32'h1600, 32'h1700, 32'h80);
    put_qtd(32'h1600, 32'h1001, 32'h1701, 32'h0005_0080);
    walk(1'b0, 32'h1802);
    chk(n_x == 2 && xl[0] == 32'h1500, "R7", xl[0], 32'h1500);
    chk(xl[1] == 32'h1600, "R7", xl[1], 32'h1600);
    chk(n_wr == 2 && wd[1] == 32'h0005_0000 && wa[1] == 32'h1608, "R8", wd[1], 32'h0005_0000);
    chk(n_fe == 2 && state_o == 4'd1, "R4", n_fe, 2);

    // R9 refused transaction: no write, horizontal exit
    clr_mem();
    nak_mode = 1'b1;
    put_qh(32'h1C00, 32'h1, 32'h0, 32'h1D00, 32'h1, 32'h1, 32'h80);
    put_qtd(32'h1D00, 32'h1, 32'h1, 32'h80);
    walk(1'b0, 32'h1C02);
    chk(n_x == 1 && n_wr == 0 && mem[32'h1D08 >> 2 & 1023] == 32'h80, "R9", n_wr, 0);
    nak_mode = 1'b0;

    // R11 periodic ring of idle QHs: exactly MAXI queue-head fetches
    clr_mem();
    put_qh(32'h1200, 32'h1242, 32'h0, 32'h0, 32'h1, 32'h1, 32'h0);
    put_qh(32'h1240, 32'h1282, 32'h0, 32'h0, 32'h1, 32'h1, 32'h0);
    put_qh(32'h1280, 32'h1202, 32'h0, 32'h0, 32'h1, 32'h1, 32'h0);
    walk(1'b0, 32'h1202);
    chk(n_qh == MAXI && n_x == 0 && state_o == 4'd1, "R11", n_qh, MAXI);

    // R3 head search wraps to start without a head
    clr_mem();
    put_qh(32'h1300, 32'h1342, 32'h0, 32'h0, 32'h1, 32'h1, 32'h0);
    put_qh(32'h1340, 32'h1302, 32'h0, 32'h0, 32'h1, 32'h1, 32'h0);
    walk(1'b1, 32'h1300);
    chk(n_hunt == 2 && n_fe == 0 && state_o == 4'd1, "R3", n_hunt, 2);

    // R3 head search limit on a long headless chain
    clr_mem();
    for (int i = 0; i < 20; i++)
      put_qh(32'h1000 + 32'h40 * i, 32'h1042 + 32'h40 * i, 32'h0, 32'h0, 32'h1, 32'h1, 32'h0);
    walk(1'b1, 32'h1000);
    chk(n_hunt == MAXI && n_fe == 0, "R3", n_hunt, MAXI);

    // R12 iso descriptor then queue head
    clr_mem();
    mem[32'h1900 >> 2 & 1023] = 32'h1842;
    put_qh(32'h1840, 32'h1, 32'h0, 32'h0, 32'h1, 32'h1, 32'h0);
    walk(1'b0, 32'h1900);
    chk(n_iso == 1 && n_qh == 1 && state_o == 4'd1, "R12", n_iso, 1);

    // R4 unknown type field ends walk
    clr_mem();
    walk(1'b0, 32'h1A04);
    chk(n_qh == 0 && n_iso == 0 && reqs_seen == 0, "R4", reqs_seen, 0);

    // R13 address hold
    chk(bad_hold == 0, "R13", bad_hold, 0);

    // R1 disable from ready
    sched_en = 1'b0;
    @(negedge clk);
    chk(state_o == 4'd0, "R1", state_o, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule